// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a serial slave that lets an external host read and write an on-chip register file over three pins: a serial clock, an active-low select and a single data line shared by both directions. The pins are oversampled by the system clock, which must run at least eight times faster than the serial clock. Every transfer opens with a 16-bit header, sent most significant bit first: a direction flag (1 = read), a two-bit length code and a 13-bit register address. One or more data bytes follow, also most significant bit first.

On the register side, the block presents a plain parallel bus. It issues a one-cycle write strobe with address and data once each written byte is complete. It issues a one-cycle read strobe whose data it captures in the same cycle. For reads, the block takes the shared data line over after the header and gives it back when the transfer ends.

A power-up mode latch samples the select pin on the first system clock after reset is released. If the select pin is high at that moment, the serial port stays inert until the next reset.

Top module: `spi3w_regport`

## Requirements
- R1: The header is taken from the first 16 rising serial-clock edges, MSB first: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the start address.
- R2: Data bits are sampled on rising serial-clock edges and assembled MSB first, so the first data bit is bit 7 of the byte.
- R3: After the eighth data bit of a write byte, the block pulses `reg_wr` for exactly one system clock, with the assembled byte on `reg_wdata` and the current address on `reg_addr`.
- R4: Length code 0 transfers 1 byte, code 1 transfers 2 bytes and code 2 transfers 3 bytes; serial clocks after the last byte cause no write, no fetch and no drive. Code 3 continues byte after byte until the select rises.
- R5: The address decreases by one after each byte of a transfer.
- R6: For a read byte, `reg_rd` pulses for one system clock on the falling serial-clock edge that precedes the byte's first bit. The captured byte is driven from the next system clock onward, MSB first, advancing one bit on each later falling edge.
- R7: `sdio_oe` stays low during the header and during writes. It rises only in the system clock after a `reg_rd` pulse, and it falls after the rising edge of the last bit of a length-limited read.
- R8: The select rising in the middle of a byte ends the transfer: the partial byte is discarded with no strobe, and `sdio_oe` goes low.
- R9: If `csn_i` is high on the first system clock after reset is released, then until the next reset `sdio_oe`, `reg_wr` and `reg_rd` stay low whatever the pins do.
- R10: During reset, and right after it, `sdio_oe`, `reg_wr` and `reg_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low select from the host; also the power-up mode pin |
| sdio_i | input | 1 | Level seen on the shared data line |
| sdio_o | output | 1 | Value the block drives on the shared data line |
| sdio_oe | output | 1 | High when the block drives the shared data line |
| reg_addr | output | ADDR_W | Register address for the current byte |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | DATA_W | Write data that goes with `reg_wr` |
| reg_rd | output | 1 | One-cycle read strobe; `reg_rdata` is captured in this cycle |
| reg_rdata | input | DATA_W | Read data from the register file |

## Verification
On every cycle, the assertions check the following:
- each strobe lasts one clock;
- the address steps down after each write;
- the driver only switches on in the clock after a fetch;
- a raised select releases the line;
- the latched inert mode keeps every output quiet;
- the block never drives while writing.

Some properties can only be shown by the host-model scenarios: the exact bit order of header and data, the byte count for each length code, the read-back values, the extra fetch that streaming reads make, discarding of an aborted partial byte, and the absence of contention with the host across complete transfers.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  // Controller phase
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_HOLD = 2'd2
  } st_e;

  // Length code carried in the header
  typedef enum logic [1:0] {
    LEN_ONE    = 2'd0,
    LEN_TWO    = 2'd1,
    LEN_THREE  = 2'd2,
    LEN_STREAM = 2'd3
  } len_e;

  // Byte budget for a length code; streaming has no budget (0)
  function automatic logic [1:0] len_bytes(input len_e c);
    logic [1:0] n;
    n = (c == LEN_STREAM) ? 2'd0 : (2'(c) + 2'd1);
    return n;
  endfunction

endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi3w_strap.sv
module spi3w_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_raw,
  output logic port_en
);

  logic done_q;
  logic en_q;

  // One-shot capture of the select level on the first clock out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      en_q   <= ~csn_raw;
    end
  end

  assign port_en = en_q;

endmodule

// File: rtl/spi3w_txshift.sv
module spi3w_txshift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         dout
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= din;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign dout = sr_q[W-1];

endmodule

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_load_o,
  output logic              tx_shift_o,
  output logic              oe_o,
  output logic              sclk_rise_o,
  output logic              byte_done_o
);

  localparam int HDR_W = 3 + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W);

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a - ADDR_W'(1);
  endfunction

  logic              sclk_q;
  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-2:0]  hdr_q;
  logic [DATA_W-2:0] rx_q;
  logic              rw_q;
  logic              stream_q;
  logic [1:0]        left_q;
  logic              wr_q;
  logic              oe_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] addr_q;

  logic              active;
  logic              rise;
  logic              fall;
  logic [HDR_W-1:0]  hdr_full;
  len_e              len_w;
  logic              hdr_last;
  logic              in_data;
  logic              byte_done;
  logic              last_byte;

  assign active    = port_en & ~csn_s;
  assign rise      = active &  sclk_s & ~sclk_q;
  assign fall      = active & ~sclk_s &  sclk_q;
  assign hdr_full  = {hdr_q, sdi_s};
  assign len_w     = len_e'(hdr_full[HDR_W-2 -: 2]);
  assign hdr_last  = (st_q == ST_HDR) && rise && (cnt_q == CNT_W'(HDR_W-1));
  assign in_data   = (st_q == ST_DATA);
  assign byte_done = in_data && rise && (cnt_q == CNT_W'(DATA_W-1));
  assign last_byte = !stream_q && (left_q == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      st_q     <= ST_HDR;
      cnt_q    <= '0;
      hdr_q    <= '0;
      rx_q     <= '0;
      rw_q     <= 1'b0;
      stream_q <= 1'b0;
      left_q   <= '0;
      wr_q     <= 1'b0;
      oe_q     <= 1'b0;
      wdata_q  <= '0;
      addr_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      wr_q   <= 1'b0;
      // step past a byte that was just committed
      if (wr_q) addr_q <= next_addr(addr_q);

      if (!active) begin
        st_q  <= ST_HDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        case (st_q)
          ST_HDR: begin
            if (rise) begin
              hdr_q <= hdr_full[HDR_W-2:0];
              cnt_q <= cnt_q + CNT_W'(1);
            end
            if (hdr_last) begin
              rw_q     <= hdr_full[HDR_W-1];
              left_q   <= len_bytes(len_w);
              stream_q <= (len_w == LEN_STREAM);
              addr_q   <= hdr_full[ADDR_W-1:0];
              cnt_q    <= '0;
              st_q     <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (rd_load_o) oe_q <= 1'b1;
            if (rise) begin
              rx_q  <= {rx_q[DATA_W-3:0], sdi_s};
              cnt_q <= cnt_q + CNT_W'(1);
            end
            if (byte_done) begin
              cnt_q <= '0;
              if (!rw_q) begin
                wr_q    <= 1'b1;
                wdata_q <= {rx_q, sdi_s};
              end else begin
                addr_q <= next_addr(addr_q);
              end
              if (last_byte) begin
                st_q <= ST_HOLD;
                oe_q <= 1'b0;
              end else if (!stream_q) begin
                left_q <= left_q - 2'd1;
              end
            end
          end
          default: begin
            oe_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign rd_load_o   = in_data && rw_q && fall && (cnt_q == '0);
  assign tx_shift_o  = in_data && rw_q && fall && (cnt_q != '0);
  assign addr_o      = addr_q;
  assign wr_o        = wr_q;
  assign wdata_o     = wdata_q;
  assign oe_o        = oe_q;
  assign sclk_rise_o = rise;
  assign byte_done_o = byte_done;

endmodule

// File: rtl/spi3w_regport.sv
module spi3w_regport #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic             csn_s;
  logic             sclk_s;
  logic             sdi_s;
  logic             port_en;
  logic             rd_load;
  logic             tx_shift;
  logic             sclk_rise;
  logic             byte_done;

  spi3w_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b101)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({csn_i, sclk_i, sdio_i}),
    .q    (pins_s)
  );

  assign csn_s  = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  spi3w_strap strap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .csn_raw(csn_i),
    .port_en(port_en)
  );

  spi3w_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .csn_s      (csn_s),
    .sclk_s     (sclk_s),
    .sdi_s      (sdi_s),
    .addr_o     (reg_addr),
    .wr_o       (reg_wr),
    .wdata_o    (reg_wdata),
    .rd_load_o  (rd_load),
    .tx_shift_o (tx_shift),
    .oe_o       (sdio_oe),
    .sclk_rise_o(sclk_rise),
    .byte_done_o(byte_done)
  );

  spi3w_txshift #(
    .W(DATA_W)
  ) tx_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (rd_load),
    .shift(tx_shift),
    .din  (reg_rdata),
    .dout (sdio_o)
  );

  assign reg_rd = rd_load;

endmodule

// File: rtl/spi3w_regport_chk.sv
module spi3w_regport_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_s,
  input logic              port_en,
  input logic              sdio_oe,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              byte_done,
  input logic [ADDR_W-1:0] reg_addr
);

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_addr == ADDR_W'($past(reg_addr) - ADDR_W'(1))));

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (!reg_rd && sdio_oe));

  // R7
  oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(reg_rd));

  // R8
  csn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdio_oe);

  // R9
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!sdio_oe && !reg_wr && !reg_rd && !byte_done));

  // R7
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !sdio_oe);

endmodule

bind spi3w_regport spi3w_regport_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn_s    (csn_s),
  .port_en  (port_en),
  .sdio_oe  (sdio_oe),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .byte_done(byte_done),
  .reg_addr (reg_addr)
);

// File: tb/spi3w_regport_tb.sv
module spi3w_regport_tb_top;

  localparam int H = 5;   // serial half period in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_i = 1'b0;
  logic        csn_i = 1'b0;
  logic        host_en = 1'b0;
  logic        host_d = 1'b0;
  logic        sdio_line;
  logic        sdio_o;
  logic        sdio_oe;
  logic [12:0] reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic        reg_rd;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int fails = 0;
  int contention = 0;
  int wr_seen = 0;
  int rd_seen = 0;
  bit oe_seen = 0;

  logic [20:0] exp_wr[$];
  logic [12:0] exp_rd[$];
  logic [7:0]  mem [256];

  always #10 clk = ~clk;

  // pull-up when nobody drives
  assign sdio_line = host_en ? host_d : (sdio_oe ? sdio_o : 1'b1);
  assign reg_rdata = mem[reg_addr[7:0]];

  spi3w_regport dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i),
    .sdio_i(sdio_line), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
  always @(posedge clk) if (reg_wr) mem[reg_addr[7:0]] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sdio_oe) oe_seen = 1;
      if (sdio_oe && host_en) contention++;
      if (reg_wr) begin
        wr_seen++;
        if (exp_wr.size() == 0) chk(0, "R4", "unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [20:0] e;
          e = exp_wr.pop_front();
          chk({reg_addr, reg_wdata} == e, "R3", "write addr/data (R2 R5)", {reg_addr, reg_wdata}, e);
        end
      end
      if (reg_rd) begin
        rd_seen++;
        if (exp_rd.size() == 0) chk(0, "R4", "unexpected fetch", reg_addr, 0);
        else begin
          logic [12:0] a;
          a = exp_rd.pop_front();
          chk(reg_addr == a, "R6", "fetch address (R5)", reg_addr, a);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, input bit drv, output logic got);
    host_en = drv;
    host_d  = b;
    wait_clk(H);
    got = sdio_oe ? sdio_o : 1'bx;
    sclk_i = 1'b1;
    wait_clk(H);
    sclk_i = 1'b0;
  endtask

  task automatic start_tx(input bit rw, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] h;
    logic g;
    h = {rw, len, a};
    csn_i = 1'b0;
    wait_clk(H);
    for (int i = 15; i >= 0; i--) sbit(h[i], 1, g);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic g;
    for (int i = 7; i >= 0; i--) sbit(b[i], 1, g);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      sbit(1'b0, 0, g);
      b[i] = g;
    end
  endtask

  task automatic end_tx;
    host_en = 1'b0;
    wait_clk(H);
    csn_i = 1'b1;
    wait_clk(3 * H);
  endtask

  task automatic do_reset(input logic csn_level);
    rst_n = 1'b0;
    csn_i = csn_level;
    wait_clk(5);
    chk(!sdio_oe && !reg_wr && !reg_rd, "R10", "outputs in reset", {sdio_oe, reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    wait_clk(4);
    csn_i = 1'b1;
    wait_clk(4);
  endtask

  initial begin
    logic [7:0] rb;
    logic [7:0] rb3[3];
    int w0;
    int r0;

    do_reset(1'b0);
    chk(!sdio_oe && !reg_wr && !reg_rd, "R10", "outputs after reset", {sdio_oe, reg_wr, reg_rd}, 0);

    // R1 R2 R3: single-byte write, asymmetric data
    exp_wr.push_back({13'h0010, 8'hA6});
    start_tx(0, 2'b00, 13'h0010); send_byte(8'hA6); end_tx();
    chk(exp_wr.size() == 0, "R3", "single write consumed", exp_wr.size(), 0);

    // R4 R5: three-byte write, address steps down
    exp_wr.push_back({13'h0022, 8'h11});
    exp_wr.push_back({13'h0021, 8'h22});
    exp_wr.push_back({13'h0020, 8'h33});
    start_tx(0, 2'b10, 13'h0022);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    end_tx();
    chk(exp_wr.size() == 0, "R5", "three writes consumed", exp_wr.size(), 0);

    // R6 R7: three-byte read-back
    exp_rd.push_back(13'h0022); exp_rd.push_back(13'h0021); exp_rd.push_back(13'h0020);
    start_tx(1, 2'b10, 13'h0022);
    for (int i = 0; i < 3; i++) recv_byte(rb3[i]);
    chk(!sdio_oe, "R7", "line released after last read bit", sdio_oe, 0);
    end_tx();
    chk(rb3[0] === 8'h11, "R6", "read byte 0", rb3[0], 8'h11);
    chk(rb3[1] === 8'h22, "R6", "read byte 1", rb3[1], 8'h22);
    chk(rb3[2] === 8'h33, "R6", "read byte 2", rb3[2], 8'h33);
    chk(exp_rd.size() == 0, "R6", "fetches consumed", exp_rd.size(), 0);

    // R4: extra clocks after a one-byte write and a one-byte read
    w0 = wr_seen;
    exp_wr.push_back({13'h0030, 8'h5B});
    start_tx(0, 2'b00, 13'h0030); send_byte(8'h5B); send_byte(8'hFF); end_tx();
    chk(wr_seen == w0 + 1, "R4", "one write for length code 0", wr_seen - w0, 1);
    r0 = rd_seen;
    exp_rd.push_back(13'h0030);
    start_tx(1, 2'b00, 13'h0030); recv_byte(rb);
    oe_seen = 0;
    recv_byte(rb3[0]);
    end_tx();
    chk(rb === 8'h5B, "R4", "one-byte read value", rb, 8'h5B);
    chk(rd_seen == r0 + 1 && !oe_seen, "R4", "no fetch/drive after budget", rd_seen - r0, 1);

    // R4 streaming write then streaming read
    for (int i = 0; i < 4; i++) exp_wr.push_back({13'(13'h0105 - i), 8'(8'hC0 + i)});
    start_tx(0, 2'b11, 13'h0105);
    for (int i = 0; i < 4; i++) send_byte(8'(8'hC0 + i));
    end_tx();
    chk(exp_wr.size() == 0, "R4", "streaming writes consumed", exp_wr.size(), 0);
    for (int i = 0; i < 5; i++) exp_rd.push_back(13'(13'h0105 - i));
    start_tx(1, 2'b11, 13'h0105);
    for (int i = 0; i < 4; i++) begin
      recv_byte(rb);
      chk(rb === 8'(8'hC0 + i), "R4", "streaming read byte", rb, 8'(8'hC0 + i));
    end
    end_tx();
    chk(!sdio_oe && exp_rd.size() == 0, "R8", "stream ends on select rise", exp_rd.size(), 0);

    // R8: write aborted mid-byte keeps only the complete byte
    exp_wr.push_back({13'h0040, 8'h77});
    start_tx(0, 2'b01, 13'h0040); send_byte(8'h77);
    begin
      logic g;
      for (int i = 0; i < 4; i++) sbit(1'b1, 1, g);
    end
    end_tx();
    exp_rd.push_back(13'h003F);
    start_tx(1, 2'b00, 13'h003F); recv_byte(rb); end_tx();
    chk(rb === (8'h3F ^ 8'h5A), "R8", "aborted byte not written", rb, 8'h3F ^ 8'h5A);

    // R8: read aborted mid-byte releases the line
    exp_rd.push_back(13'h0020);
    start_tx(1, 2'b11, 13'h0020);
    begin
      logic g;
      for (int i = 0; i < 3; i++) sbit(1'b0, 0, g);
    end
    csn_i = 1'b1;
    wait_clk(4);
    chk(!sdio_oe, "R8", "line released on mid-byte abort", sdio_oe, 0);
    wait_clk(2 * H);

    chk(contention == 0, "R7", "no drive while host drives", contention, 0);

    // R9: select high at reset release keeps port inert
    do_reset(1'b1);
    w0 = wr_seen; r0 = rd_seen; oe_seen = 0;
    start_tx(0, 2'b00, 13'h0010); send_byte(8'h99); end_tx();
    start_tx(1, 2'b00, 13'h0010); recv_byte(rb); end_tx();
    chk(wr_seen == w0 && rd_seen == r0, "R9", "no strobes when inert", wr_seen - w0 + rd_seen - r0, 0);
    chk(!oe_seen, "R9", "no drive when inert", oe_seen, 0);

    // R9: next reset with select low restores the port
    do_reset(1'b0);
    exp_wr.push_back({13'h0011, 8'h3D});
    start_tx(0, 2'b00, 13'h0011); send_byte(8'h3D); end_tx();
    chk(exp_wr.size() == 0, "R9", "port works after normal reset", exp_wr.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule